// File: doc/BRIEF.md
# Quad Channel Slot-Multiplexed Receive Interface

This block gathers four independent receive bit streams and places them on four shared serial outputs: carrier, data valid, data and collision. The outputs take turns by time slot. A free-running slot counter visits channels 0, 1, 2 and 3 in that order, and in each cycle the shared outputs carry the state of the channel whose slot is current. All inputs are per-channel strobes and flags that are already synchronous to the system clock. Each channel delivers a bit-valid strobe with a bit, a carrier flag, a collision flag and a request that marks the end of a transmitted packet for the collision self-test.

Received bits do not arrive at the slot rate, so each channel stores them in a small elasticity buffer. Data valid and data are taken from that buffer, and carrier goes straight to the output. Data therefore trails carrier by a lag that varies but stays bounded. A buffer begins to emit only when it holds enough bits to ride out jitter, or when carrier has dropped. After carrier drops it drains what is left. A single strobe input acts both as synchronous reset and as slot alignment.

Top module: `qrx_slot_mux`

## Requirements
- R1: While `rst_strobe` is high at a clock edge, the slot index is 0 after that edge. The same edge empties every buffer, clears every overflow flag and clears the carrier, collision and self-test state. The outputs `mux_crs`, `mux_vld` and `mux_col` are then 0, even when the channel inputs are active.
- R2: Each clock edge with `rst_strobe` low advances `slot_idx` by one, modulo 4. The value k on `slot_idx` means the shared outputs carry channel k.
- R3: In slot k, `mux_crs` equals `rx_carrier[k]` as captured at the previous clock edge. Carrier does not wait for any buffered data.
- R4: Bits accepted on channel k come out on `mux_data` in the order they arrived. At most one bit is emitted per occurrence of slot k, and `mux_vld` is high exactly in the slots that carry a bit.
- R5: While carrier is high, a channel starts emitting only once its buffer holds at least 4 bits. With fewer bits stored, `mux_vld` stays low in that channel's slot.
- R6: Once carrier is low, a channel emits its remaining bits even if fewer than 4 are stored. After its buffer is empty, `mux_vld` stays low in its slot.
- R7: Each buffer holds 8 bits. A burst of 8 bits arriving one every two cycles while carrier is high loses no bit and raises no overflow flag.
- R8: A bit that arrives when the buffer is full and no bit leaves in that cycle is dropped, and `ovf_err[k]` goes high. The flag stays high until the strobe. The first 8 bits of the frame still come out intact.
- R9: In slot k, `mux_col` is high when `rx_collision[k]` was high at the previous clock edge. Collision on channel k never shows in another channel's slot.
- R10: A one-cycle pulse on `tx_sqe_req[k]` with `sqe_test_dis` low raises `mux_col` in exactly one following occurrence of slot k. With `sqe_test_dis` high the pulse has no effect on `mux_col`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_strobe | input | 1 | Synchronous reset and slot alignment strobe, active high |
| rx_bit_vld | input | 4 | Per-channel strobe: a received bit is present |
| rx_bit | input | 4 | Per-channel received bit |
| rx_carrier | input | 4 | Per-channel receive activity flag |
| rx_collision | input | 4 | Per-channel collision flag |
| tx_sqe_req | input | 4 | Per-channel end-of-transmit pulse requesting a collision self-test indication |
| sqe_test_dis | input | 1 | When high, self-test requests are ignored |
| slot_idx | output | 2 | Channel whose slot is current |
| mux_crs | output | 1 | Shared carrier output |
| mux_vld | output | 1 | Shared data valid output |
| mux_data | output | 1 | Shared data output |
| mux_col | output | 1 | Shared collision output |
| ovf_err | output | 4 | Per-channel sticky buffer overflow flags |

## Verification
Carrier, collision and self-test state each pass through one register. They show in the slot that is current one edge after the input changes, so the bench drives inputs just after a falling edge and samples at the falling edge after the next rising edge. It then checks the output against the slot index over a window of at least two slot rounds. Data timing depends on buffer fill, so a falling-edge monitor logs every valid bit by slot, and each scenario compares the newly logged bits with the bits it pushed once enough cycles have passed for the buffer to drain. The threshold and drain cases also check that nothing was logged before carrier dropped or the fourth bit arrived. The overflow flag is read a few cycles after the burst, after the drain, and again after the strobe.

// File: rtl/qrx_pkg.sv
package qrx_pkg;

  // Next slot number, wrapping after the last channel.
  function automatic int slot_after(int cur, int n_ch);
    return (cur + 1 >= n_ch) ? 0 : cur + 1;
  endfunction

  // A channel may emit when already emitting, when enough bits are stored,
  // or when carrier has dropped and anything is left to drain.
  function automatic logic may_emit(logic emitting, int level, int thresh,
                                    logic carrier);
    return emitting || (level >= thresh) || (!carrier && level != 0);
  endfunction

  // Pointer increment with explicit wrap at the buffer depth.
  function automatic int ptr_after(int cur, int depth);
    return (cur + 1 >= depth) ? 0 : cur + 1;
  endfunction

endpackage

// File: rtl/qrx_slot_ctr.sv
module qrx_slot_ctr #(
  parameter  int NUM_CH = 4,
  localparam int SW     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_strobe,
  output logic [SW-1:0]     slot_o,
  output logic [NUM_CH-1:0] slot_hot_o
);

  logic [SW-1:0] slot_q;

  always_ff @(posedge clk) begin
    if (rst_strobe) slot_q <= '0;
    else            slot_q <= SW'(qrx_pkg::slot_after(int'(slot_q), NUM_CH));
  end

  assign slot_o = slot_q;

  for (genvar k = 0; k < NUM_CH; k++) begin : g_hot
    assign slot_hot_o[k] = (slot_q == SW'(k));
  end

endmodule

// File: rtl/qrx_chan_flags.sv
module qrx_chan_flags (
  input  logic clk,
  input  logic rst_strobe,
  input  logic carrier_i,
  input  logic coll_i,
  input  logic sqe_req_i,
  input  logic sqe_dis_i,
  input  logic my_slot_i,
  output logic crs_o,
  output logic col_o,
  output logic pend_o
);

  logic crs_q, col_q, pend_q;
  logic sqe_shown, sqe_arm;

  // Self-test indication is consumed in the slot where it is shown.
  assign sqe_shown = pend_q & my_slot_i;
  assign sqe_arm   = sqe_req_i & ~sqe_dis_i;

  always_ff @(posedge clk) begin
    if (rst_strobe) begin
      crs_q  <= 1'b0;
      col_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      crs_q  <= carrier_i;
      col_q  <= coll_i;
      pend_q <= (pend_q & ~sqe_shown) | sqe_arm;
    end
  end

  assign crs_o  = crs_q;
  assign col_o  = col_q;
  assign pend_o = pend_q;

endmodule

// File: rtl/qrx_chan_buf.sv
module qrx_chan_buf #(
  parameter  int DEPTH  = 8,
  parameter  int THRESH = 4,
  localparam int PW     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW     = $clog2(DEPTH + 1)
) (
  input  logic clk,
  input  logic rst_strobe,
  input  logic push_i,
  input  logic bit_i,
  input  logic carrier_q_i,
  input  logic my_slot_i,
  output logic pop_o,
  output logic head_o,
  output logic ovf_o
);

  logic [DEPTH-1:0] mem_q;
  logic [PW-1:0]    wr_q, rd_q;
  logic [LW-1:0]    lvl_q, lvl_nxt;
  logic             emit_q, ovf_q;
  logic             full, empty, start_ok, accept, ovf_ev;

  assign full  = (lvl_q == LW'(DEPTH));
  assign empty = (lvl_q == '0);

  always_comb begin
    start_ok = qrx_pkg::may_emit(emit_q, int'(lvl_q), THRESH, carrier_q_i);
    pop_o    = my_slot_i & start_ok & ~empty;
    accept   = push_i & (~full | pop_o);
    ovf_ev   = push_i & full & ~pop_o;
    lvl_nxt  = lvl_q + LW'(accept) - LW'(pop_o);
  end

  always_ff @(posedge clk) begin
    if (rst_strobe) begin
      mem_q  <= '0;
      wr_q   <= '0;
      rd_q   <= '0;
      lvl_q  <= '0;
      emit_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      if (accept) begin
        mem_q[wr_q] <= bit_i;
        wr_q        <= PW'(qrx_pkg::ptr_after(int'(wr_q), DEPTH));
      end
      if (pop_o) rd_q <= PW'(qrx_pkg::ptr_after(int'(rd_q), DEPTH));
      lvl_q  <= lvl_nxt;
      emit_q <= start_ok & (lvl_nxt != '0);
      if (ovf_ev) ovf_q <= 1'b1;
    end
  end

  assign head_o = mem_q[rd_q];
  assign ovf_o  = ovf_q;

endmodule

// File: rtl/qrx_slot_pick.sv
module qrx_slot_pick #(
  parameter  int NUM_CH = 4,
  localparam int SW     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [SW-1:0]     sel_i,
  input  logic [NUM_CH-1:0] crs_vec_i,
  input  logic [NUM_CH-1:0] vld_vec_i,
  input  logic [NUM_CH-1:0] dat_vec_i,
  input  logic [NUM_CH-1:0] col_vec_i,
  output logic              crs_o,
  output logic              vld_o,
  output logic              dat_o,
  output logic              col_o
);

  always_comb begin
    crs_o = crs_vec_i[sel_i];
    vld_o = vld_vec_i[sel_i];
    dat_o = vld_vec_i[sel_i] & dat_vec_i[sel_i];
    col_o = col_vec_i[sel_i];
  end

endmodule

// File: rtl/qrx_slot_mux.sv
module qrx_slot_mux #(
  parameter  int NUM_CH    = 4,
  parameter  int BUF_DEPTH = 8,
  parameter  int START_LVL = 4,
  localparam int SW        = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_strobe,
  input  logic [NUM_CH-1:0] rx_bit_vld,
  input  logic [NUM_CH-1:0] rx_bit,
  input  logic [NUM_CH-1:0] rx_carrier,
  input  logic [NUM_CH-1:0] rx_collision,
  input  logic [NUM_CH-1:0] tx_sqe_req,
  input  logic              sqe_test_dis,
  output logic [SW-1:0]     slot_idx,
  output logic              mux_crs,
  output logic              mux_vld,
  output logic              mux_data,
  output logic              mux_col,
  output logic [NUM_CH-1:0] ovf_err
);

  logic [NUM_CH-1:0] slot_hot;
  logic [NUM_CH-1:0] crs_vec, colq_vec, pend_vec, col_vec;
  logic [NUM_CH-1:0] pop_vec, head_vec;

  qrx_slot_ctr #(.NUM_CH(NUM_CH)) u_slot (
    .clk        (clk),
    .rst_strobe (rst_strobe),
    .slot_o     (slot_idx),
    .slot_hot_o (slot_hot)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    qrx_chan_flags u_flags (
      .clk        (clk),
      .rst_strobe (rst_strobe),
      .carrier_i  (rx_carrier[k]),
      .coll_i     (rx_collision[k]),
      .sqe_req_i  (tx_sqe_req[k]),
      .sqe_dis_i  (sqe_test_dis),
      .my_slot_i  (slot_hot[k]),
      .crs_o      (crs_vec[k]),
      .col_o      (colq_vec[k]),
      .pend_o     (pend_vec[k])
    );

    qrx_chan_buf #(.DEPTH(BUF_DEPTH), .THRESH(START_LVL)) u_buf (
      .clk         (clk),
      .rst_strobe  (rst_strobe),
      .push_i      (rx_bit_vld[k]),
      .bit_i       (rx_bit[k]),
      .carrier_q_i (crs_vec[k]),
      .my_slot_i   (slot_hot[k]),
      .pop_o       (pop_vec[k]),
      .head_o      (head_vec[k]),
      .ovf_o       (ovf_err[k])
    );
  end

  assign col_vec = colq_vec | pend_vec;

  qrx_slot_pick #(.NUM_CH(NUM_CH)) u_pick (
    .sel_i     (slot_idx),
    .crs_vec_i (crs_vec),
    .vld_vec_i (pop_vec),
    .dat_vec_i (head_vec),
    .col_vec_i (col_vec),
    .crs_o     (mux_crs),
    .vld_o     (mux_vld),
    .dat_o     (mux_data),
    .col_o     (mux_col)
  );

endmodule

// File: rtl/qrx_slot_mux_chk.sv
module qrx_slot_mux_chk #(
  parameter  int NUM_CH = 4,
  localparam int SW     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input logic              clk,
  input logic              rst_strobe,
  input logic [NUM_CH-1:0] rx_carrier,
  input logic [NUM_CH-1:0] rx_collision,
  input logic [SW-1:0]     slot_idx,
  input logic              mux_crs,
  input logic              mux_vld,
  input logic              mux_col,
  input logic [NUM_CH-1:0] ovf_err,
  input logic [NUM_CH-1:0] pend_vec
);

  logic              armed;
  logic [NUM_CH-1:0] car_d, col_d;

  always_ff @(posedge clk) begin
    armed <= armed | rst_strobe;
    car_d <= rx_carrier;
    col_d <= rx_collision;
  end

  p_clear_r1: assert property (@(posedge clk) disable iff (rst_strobe)
    armed && $fell(rst_strobe) |-> !mux_crs && !mux_vld && !mux_col && ovf_err == '0);

  p_slot_step_r2: assert property (@(posedge clk) disable iff (rst_strobe)
    armed |=> slot_idx == (($past(slot_idx) == SW'(NUM_CH - 1)) ? '0 : $past(slot_idx) + SW'(1)));

  p_crs_source_r3: assert property (@(posedge clk) disable iff (rst_strobe)
    armed && mux_crs |-> car_d[slot_idx]);

  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (rst_strobe)
    armed |=> (ovf_err & $past(ovf_err)) == $past(ovf_err));

  p_col_source_r9: assert property (@(posedge clk) disable iff (rst_strobe)
    armed && mux_col |-> col_d[slot_idx] || pend_vec[slot_idx]);

endmodule

bind qrx_slot_mux qrx_slot_mux_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk          (clk),
  .rst_strobe   (rst_strobe),
  .rx_carrier   (rx_carrier),
  .rx_collision (rx_collision),
  .slot_idx     (slot_idx),
  .mux_crs      (mux_crs),
  .mux_vld      (mux_vld),
  .mux_col      (mux_col),
  .ovf_err      (ovf_err),
  .pend_vec     (pend_vec)
);

// File: tb/test_qrx_slot_mux.sv
`timescale 1ns/1ps
module test_qrx_slot_mux;

  logic       clk = 1'b0;
  logic       rst_strobe;
  logic [3:0] rx_bit_vld, rx_bit, rx_carrier, rx_collision, tx_sqe_req;
  logic       sqe_test_dis;
  logic [1:0] slot_idx;
  logic       mux_crs, mux_vld, mux_data, mux_col;
  logic [3:0] ovf_err;

  always #4 clk = ~clk;

  qrx_slot_mux i_qrx_slot_mux (
    .clk(clk), .rst_strobe(rst_strobe), .rx_bit_vld(rx_bit_vld), .rx_bit(rx_bit),
    .rx_carrier(rx_carrier), .rx_collision(rx_collision), .tx_sqe_req(tx_sqe_req),
    .sqe_test_dis(sqe_test_dis), .slot_idx(slot_idx), .mux_crs(mux_crs),
    .mux_vld(mux_vld), .mux_data(mux_data), .mux_col(mux_col), .ovf_err(ovf_err)
  );

  int n_chk = 0;
  int n_fail = 0;

  // Monitor: log every emitted bit per slot; track slot stepping (R2).
  logic [255:0] got_bits [4];
  int           got_n [4];
  int           slot_err = 0;
  int           prev_slot = -1;

  initial for (int c = 0; c < 4; c++) begin got_n[c] = 0; got_bits[c] = '0; end

  always @(negedge clk) begin
    if (rst_strobe !== 1'b0) prev_slot = -1;
    else begin
      if (prev_slot >= 0 && int'(slot_idx) != (prev_slot + 1) % 4) slot_err++;
      prev_slot = int'(slot_idx);
      if (mux_vld === 1'b1 && got_n[slot_idx] < 256) begin
        got_bits[slot_idx][got_n[slot_idx]] = mux_data;
        got_n[slot_idx]++;
      end
    end
  end

  logic [255:0] sent_bits [4];
  int           sent_n [4];

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_seq(int ch, logic [31:0] pat, int n, int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      rx_bit_vld[ch] = 1'b1;
      rx_bit[ch]     = pat[i];
      sent_bits[ch][sent_n[ch]] = pat[i];
      sent_n[ch]++;
      @(negedge clk); #1;
      rx_bit_vld[ch] = 1'b0;
      repeat (gap) @(negedge clk);
    end
  endtask

  function automatic logic [31:0] got_seq(int ch, int base, int n);
    logic [31:0] r = '0;
    for (int i = 0; i < n; i++) r[i] = got_bits[ch][base + i];
    return r;
  endfunction

  function automatic logic [31:0] sent_seq(int ch, int base, int n);
    logic [31:0] r = '0;
    for (int i = 0; i < n; i++) r[i] = sent_bits[ch][base + i];
    return r;
  endfunction

  task automatic t_reset_state;
    cyc(3);
    check("R1", "slot under strobe", int'(slot_idx), 0);
    check("R1", "outputs under strobe", int'({mux_crs, mux_vld, mux_col}), 0);
    check("R1", "overflow flags under strobe", int'(ovf_err), 0);
    #1;
    rx_carrier = '0; rx_collision = '0;
    rst_strobe = 1'b0;
  endtask

  task automatic t_slots;
    int bad = 0;
    int prv;
    @(negedge clk);
    check("R2", "first slot after release", int'(slot_idx), 1);
    prv = int'(slot_idx);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (int'(slot_idx) != (prv + 1) % 4) bad++;
      prv = int'(slot_idx);
    end
    check("R2", "slot step errors", bad, 0);
  endtask

  task automatic t_carrier;
    int bad = 0, vld_seen = 0;
    @(negedge clk); #1; rx_carrier[2] = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (mux_crs != (slot_idx == 2'd2)) bad++;
      if (mux_vld) vld_seen++;
    end
    check("R3", "carrier slot mismatches", bad, 0);
    check("R3", "valid without data", vld_seen, 0);
    #1; rx_carrier[2] = 1'b0;
    cyc(2);
  endtask

  task automatic t_threshold;
    int gb = got_n[0];
    int sb = sent_n[0];
    @(negedge clk); #1; rx_carrier[0] = 1'b1;
    push_seq(0, 32'b101, 3, 2);
    cyc(24);
    check("R5", "bits emitted below threshold", got_n[0] - gb, 0);
    push_seq(0, 32'b1, 1, 2);
    cyc(16);
    check("R5", "emission started at threshold", int'(got_n[0] - gb > 0), 1);
    #1; rx_carrier[0] = 1'b0;
    cyc(12);
    check("R4", "bit count ch0", got_n[0] - gb, 4);
    check("R4", "bit order ch0", int'(got_seq(0, gb, 4)), int'(sent_seq(0, sb, 4)));
  endtask

  task automatic t_drain;
    int gb = got_n[1];
    int sb = sent_n[1];
    @(negedge clk); #1; rx_carrier[1] = 1'b1;
    push_seq(1, 32'b10, 2, 2);
    cyc(20);
    check("R6", "held while carrier high", got_n[1] - gb, 0);
    #1; rx_carrier[1] = 1'b0;
    cyc(20);
    check("R6", "drained count", got_n[1] - gb, 2);
    check("R6", "drained order", int'(got_seq(1, gb, 2)), int'(sent_seq(1, sb, 2)));
    cyc(20);
    check("R6", "quiet after drain", got_n[1] - gb, 2);
  endtask

  task automatic t_burst;
    int gb = got_n[2];
    int sb = sent_n[2];
    @(negedge clk); #1; rx_carrier[2] = 1'b1;
    push_seq(2, 32'b1011_0010, 8, 0);
    cyc(16);
    #1; rx_carrier[2] = 1'b0;
    cyc(40);
    check("R7", "no overflow on 8-bit burst", int'(ovf_err), 0);
    check("R7", "burst count", got_n[2] - gb, 8);
    check("R7", "burst order", int'(got_seq(2, gb, 8)), int'(sent_seq(2, sb, 8)));
  endtask

  task automatic t_overflow;
    int gb = got_n[3];
    int sb = sent_n[3];
    @(negedge clk); #1; rx_carrier[3] = 1'b1;
    push_seq(3, 32'hC3A5_96F0, 32, 0);
    cyc(2);
    check("R8", "overflow flag after flood", int'(ovf_err), 8);
    #1; rx_carrier[3] = 1'b0;
    cyc(80);
    check("R8", "dropped bits", int'(got_n[3] - gb < 32), 1);
    check("R8", "first 8 bits intact", int'(got_seq(3, gb, 8)), int'(sent_seq(3, sb, 8)));
    check("R8", "flag sticky after drain", int'(ovf_err), 8);
    @(negedge clk); #1; rst_strobe = 1'b1;
    cyc(2);
    check("R1", "strobe clears overflow", int'(ovf_err), 0);
    #1; rst_strobe = 1'b0;
    cyc(2);
  endtask

  task automatic t_collision;
    int bad = 0, stray = 0;
    @(negedge clk); #1; rx_collision[3] = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (mux_col != (slot_idx == 2'd3)) bad++;
    end
    check("R9", "collision slot mismatches", bad, 0);
    #1; rx_collision[3] = 1'b0;
    cyc(2);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (mux_col) stray++;
    end
    check("R9", "collision cleared", stray, 0);
  endtask

  task automatic t_sqe;
    int own = 0, other = 0;
    @(negedge clk); #1; sqe_test_dis = 1'b0; tx_sqe_req[1] = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (mux_col && slot_idx == 2'd1) own++;
      if (mux_col && slot_idx != 2'd1) other++;
      #1; tx_sqe_req[1] = 1'b0;
    end
    check("R10", "self-test shown once in own slot", own, 1);
    check("R10", "self-test in other slots", other, 0);
    own = 0;
    @(negedge clk); #1; sqe_test_dis = 1'b1; tx_sqe_req[1] = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (mux_col) own++;
      #1; tx_sqe_req[1] = 1'b0;
    end
    check("R10", "self-test ignored when disabled", own, 0);
  endtask

  initial begin
    rst_strobe = 1'b1;
    rx_bit_vld = '0; rx_bit = '0; tx_sqe_req = '0; sqe_test_dis = 1'b0;
    rx_carrier = 4'hF; rx_collision = 4'hF;
    for (int c = 0; c < 4; c++) begin sent_n[c] = 0; sent_bits[c] = '0; end
    t_reset_state();
    t_slots();
    t_carrier();
    t_threshold();
    t_drain();
    t_burst();
    t_overflow();
    t_collision();
    t_sqe();
    check("R2", "monitor slot step errors", slot_err, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(8 * 150000);
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
    $finish;
  end

endmodule